// File: doc/BRIEF.md
# Vertical gate-scan timing generator

This block drives the row-select side of an active-matrix LCD panel. It takes a master clock, a line strobe at the start of every horizontal period and a frame strobe at the start of every field. From these it produces the vertical start pulse and two complementary row-shift clocks that advance one row per line. It also produces a gate-enable window and a precharge pulse, each placed at a fixed position inside the line, and a scan-direction level for the panel.

All pulse positions are counted in master-clock ticks from the clock edge that samples the line strobe. Delays and widths are given as nanosecond parameters and rounded to ticks at elaboration, against a nominal line period. Elaboration stops with an error if the enable or precharge window does not fit inside one line, or if the two windows overlap.

After a frame strobe, the next line is a lead-in line. The vertical start pulse rises in the second half of that line. The following NUM_LINES line strobes each select one row. The strobe that closes the last row ends the scan, and the block then waits for the next frame strobe.

Top module: `vscan_gen`

"Tick k" below means the state after the k-th rising clock edge that follows the edge that sampled the line strobe. Values are for the default timing parameters: 125 ns tick, 64 µs line, so a line is 512 ticks.

## Requirements
- R1: `scan_dir_o` takes `scan_down_i` (1 = down scan, 0 = up scan) at the edge that samples a frame strobe. It holds that value until the next frame strobe, whatever `scan_down_i` does in between.
- R2: The line opened by the first line strobe after a frame strobe is a lead-in line. The row clocks do not toggle, and `gate_en_o` and `prechg_o` stay low. `vst_o` rises at tick 256 of this line (32 µs before the nominal next strobe).
- R3: `vst_o` stays high into the first row line and falls at tick 256 of it (32 µs after the first row-clock edge).
- R4: Each line strobe that opens row 1 to NUM_LINES toggles `vclk_a_o` at the edge that samples it. `vclk_b_o` is always the inverse of `vclk_a_o`.
- R5: In every row line, `gate_en_o` is high exactly for ticks 18 to 65: it rises 2.25 µs after the row-clock edge and is 6 µs wide.
- R6: In every row line, `prechg_o` is high exactly for ticks 484 to 503: it is 2.5 µs wide and falls 1 µs before the nominal next row-clock edge.
- R7: The line strobe that closes row NUM_LINES sets `done_o`. After that the row clocks hold, and no enable or precharge pulse appears. The next frame strobe clears `done_o`.
- R8: When a frame strobe and a line strobe fall in the same cycle, the frame strobe wins. That line strobe does not open the lead-in line.
- R9: After reset all pulse outputs are low, `vclk_a_o` is 0, `vclk_b_o` is 1, and `done_o` and `scan_dir_o` are 0.
- R10: Line strobes that arrive before any frame strobe are ignored. The row clocks do not move and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_stb_i | input | 1 | One-cycle strobe at the start of each horizontal period |
| frame_stb_i | input | 1 | One-cycle strobe that arms a new vertical scan |
| scan_down_i | input | 1 | Requested scan direction, 1 = down |
| vst_o | output | 1 | Vertical start pulse |
| vclk_a_o | output | 1 | Row-shift clock, phase A |
| vclk_b_o | output | 1 | Row-shift clock, phase B (inverse of A) |
| gate_en_o | output | 1 | Gate-enable window |
| prechg_o | output | 1 | Precharge pulse |
| scan_dir_o | output | 1 | Scan direction held for the current frame |
| done_o | output | 1 | All rows of the frame have been selected |

## Verification
A frame strobe and a line strobe can land in the same cycle. Without a priority rule, that line strobe would open the lead-in line early and pull the start pulse one line forward. The bench drives both strobes on the same edge. It then looks at tick 300 of the line that follows: `vst_o` must still be low there, and the row clocks must not have toggled. The end of the scan is also exercised: the strobe that closes the last row must raise `done_o` while leaving the row clocks and the enable window quiet.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_LEAD,
    ST_ACTIVE,
    ST_DONE
  } scan_st_e;

  // round-to-nearest conversion of a duration to clock ticks
  function automatic int ns_to_ticks(input int ns, input int tick_ns);
    return (ns + tick_ns / 2) / tick_ns;
  endfunction

endpackage

// File: rtl/vscan_line_timer.sv
module vscan_line_timer #(
  parameter int TW   = 10,
  parameter int TMAX = 1023
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  output logic [TW-1:0] tick_d_o
);

  localparam logic [TW-1:0] TickMax = TW'(TMAX);

  logic [TW-1:0] tick_q;

  // saturate so a missing strobe cannot wrap into a new window
  always_comb begin
    if (restart_i)              tick_d_o = '0;
    else if (tick_q == TickMax) tick_d_o = tick_q;
    else                        tick_d_o = tick_q + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= TickMax;
    else         tick_q <= tick_d_o;
  end

endmodule

// File: rtl/vscan_seq.sv
module vscan_seq
  import vscan_pkg::*;
#(
  parameter int NUM_LINES = 225
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     frame_stb_i,
  input  logic     line_stb_i,
  input  logic     scan_down_i,
  output scan_st_e st_d_o,
  output logic     first_d_o,
  output logic     vclk_a_o,
  output logic     scan_dir_o,
  output logic     done_o
);

  localparam int LW = $clog2(NUM_LINES + 1);
  localparam logic [LW-1:0] LastLine = LW'(NUM_LINES);

  scan_st_e      st_q;
  logic [LW-1:0] ln_q, ln_d;
  logic          toggle;

  always_comb begin
    st_d_o = st_q;
    ln_d   = ln_q;
    if (frame_stb_i) begin
      st_d_o = ST_ARMED;
      ln_d   = '0;
    end else if (line_stb_i) begin
      unique case (st_q)
        ST_ARMED: st_d_o = ST_LEAD;
        ST_LEAD: begin
          st_d_o = ST_ACTIVE;
          ln_d   = LW'(1);
        end
        ST_ACTIVE: begin
          if (ln_q == LastLine) st_d_o = ST_DONE;
          else                  ln_d   = ln_q + LW'(1);
        end
        default: st_d_o = st_q;
      endcase
    end
  end

  assign toggle    = line_stb_i && !frame_stb_i && (st_d_o == ST_ACTIVE);
  assign first_d_o = (st_d_o == ST_ACTIVE) && (ln_d == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ln_q       <= '0;
      vclk_a_o   <= 1'b0;
      scan_dir_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      st_q     <= st_d_o;
      ln_q     <= ln_d;
      vclk_a_o <= vclk_a_o ^ toggle;
      if (frame_stb_i) scan_dir_o <= scan_down_i;
      done_o   <= (st_d_o == ST_DONE);
    end
  end

endmodule

// File: rtl/vscan_pulse_dec.sv
module vscan_pulse_dec
  import vscan_pkg::*;
#(
  parameter int TW          = 10,
  parameter int LINE_T      = 512,
  parameter int EN_DLY_T    = 18,
  parameter int EN_WID_T    = 48,
  parameter int PCG_WID_T   = 20,
  parameter int PCG_LEAD_T  = 8,
  parameter int VST_SETUP_T = 256,
  parameter int VST_HOLD_T  = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] tick_d_i,
  input  scan_st_e      st_d_i,
  input  logic          first_d_i,
  output logic          gate_en_o,
  output logic          prechg_o,
  output logic          vst_o
);

  localparam logic [TW-1:0] EnLo  = TW'(EN_DLY_T);
  localparam logic [TW-1:0] EnHi  = TW'(EN_DLY_T + EN_WID_T);
  localparam logic [TW-1:0] PcgLo = TW'(LINE_T - PCG_LEAD_T - PCG_WID_T);
  localparam logic [TW-1:0] PcgHi = TW'(LINE_T - PCG_LEAD_T);
  localparam logic [TW-1:0] VsLo  = TW'(LINE_T - VST_SETUP_T);
  localparam logic [TW-1:0] VsHi  = TW'(VST_HOLD_T);

  logic active_d, en_d, pcg_d, vst_d;

  // decode from next-state values so outputs align with the strobe edge
  assign active_d = (st_d_i == ST_ACTIVE);
  assign en_d     = active_d && (tick_d_i >= EnLo)  && (tick_d_i < EnHi);
  assign pcg_d    = active_d && (tick_d_i >= PcgLo) && (tick_d_i < PcgHi);
  assign vst_d    = ((st_d_i == ST_LEAD) && (tick_d_i >= VsLo)) ||
                    (first_d_i && (tick_d_i < VsHi));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_en_o <= 1'b0;
      prechg_o  <= 1'b0;
      vst_o     <= 1'b0;
    end else begin
      gate_en_o <= en_d;
      prechg_o  <= pcg_d;
      vst_o     <= vst_d;
    end
  end

endmodule

// File: rtl/vscan_gen.sv
module vscan_gen
  import vscan_pkg::*;
#(
  parameter int NUM_LINES    = 225,
  parameter int TICK_NS      = 125,
  parameter int LINE_NS      = 64000,
  parameter int EN_DLY_NS    = 2200,
  parameter int EN_WID_NS    = 6000,
  parameter int PCG_WID_NS   = 2500,
  parameter int PCG_LEAD_NS  = 1000,
  parameter int VST_SETUP_NS = 32000,
  parameter int VST_HOLD_NS  = 32000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_stb_i,
  input  logic frame_stb_i,
  input  logic scan_down_i,
  output logic vst_o,
  output logic vclk_a_o,
  output logic vclk_b_o,
  output logic gate_en_o,
  output logic prechg_o,
  output logic scan_dir_o,
  output logic done_o
);

  localparam int LINE_T      = ns_to_ticks(LINE_NS, TICK_NS);
  localparam int EN_DLY_T    = ns_to_ticks(EN_DLY_NS, TICK_NS);
  localparam int EN_WID_T    = ns_to_ticks(EN_WID_NS, TICK_NS);
  localparam int PCG_WID_T   = ns_to_ticks(PCG_WID_NS, TICK_NS);
  localparam int PCG_LEAD_T  = ns_to_ticks(PCG_LEAD_NS, TICK_NS);
  localparam int VST_SETUP_T = ns_to_ticks(VST_SETUP_NS, TICK_NS);
  localparam int VST_HOLD_T  = ns_to_ticks(VST_HOLD_NS, TICK_NS);
  localparam int TMAX        = 2 * LINE_T;
  localparam int TW          = $clog2(TMAX + 1);

  if ((EN_DLY_T + EN_WID_T > LINE_T - PCG_LEAD_T - PCG_WID_T) ||
      (PCG_LEAD_T + PCG_WID_T > LINE_T) ||
      (VST_SETUP_T > LINE_T) || (VST_HOLD_T > LINE_T) ||
      (EN_WID_T < 1) || (PCG_WID_T < 1)) begin : g_bad_timing
    $error("vscan_gen: enable/precharge windows do not fit one line");
  end

  logic [TW-1:0] tick_d;
  scan_st_e      st_d;
  logic          first_d;

  vscan_line_timer #(
    .TW  (TW),
    .TMAX(TMAX)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(line_stb_i),
    .tick_d_o (tick_d)
  );

  vscan_seq #(
    .NUM_LINES(NUM_LINES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_stb_i(frame_stb_i),
    .line_stb_i (line_stb_i),
    .scan_down_i(scan_down_i),
    .st_d_o     (st_d),
    .first_d_o  (first_d),
    .vclk_a_o   (vclk_a_o),
    .scan_dir_o (scan_dir_o),
    .done_o     (done_o)
  );

  vscan_pulse_dec #(
    .TW         (TW),
    .LINE_T     (LINE_T),
    .EN_DLY_T   (EN_DLY_T),
    .EN_WID_T   (EN_WID_T),
    .PCG_WID_T  (PCG_WID_T),
    .PCG_LEAD_T (PCG_LEAD_T),
    .VST_SETUP_T(VST_SETUP_T),
    .VST_HOLD_T (VST_HOLD_T)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_d_i (tick_d),
    .st_d_i   (st_d),
    .first_d_i(first_d),
    .gate_en_o(gate_en_o),
    .prechg_o (prechg_o),
    .vst_o    (vst_o)
  );

  assign vclk_b_o = ~vclk_a_o;

endmodule

// File: rtl/vscan_gen_chk.sv
module vscan_gen_chk #(
  parameter int EN_W = 48
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_stb_i,
  input logic frame_stb_i,
  input logic vclk_a_o,
  input logic vclk_b_o,
  input logic gate_en_o,
  input logic prechg_o,
  input logic scan_dir_o,
  input logic done_o
);

  logic [15:0] en_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_run <= '0;
    else if (gate_en_o) en_run <= en_run + 16'd1;
    else                en_run <= '0;
  end

  p_vclk_compl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vclk_a_o != vclk_b_o);

  p_vclk_on_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vclk_a_o) |-> $past(line_stb_i));

  p_en_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> (en_run < 16'(EN_W)));

  p_en_pcg_apart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_en_o && prechg_o));

  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!gate_en_o && !prechg_o));

  p_dir_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_stb_i) |-> $stable(scan_dir_o));

endmodule

bind vscan_gen vscan_gen_chk #(.EN_W(EN_WID_T)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_stb_i (line_stb_i),
  .frame_stb_i(frame_stb_i),
  .vclk_a_o   (vclk_a_o),
  .vclk_b_o   (vclk_b_o),
  .gate_en_o  (gate_en_o),
  .prechg_o   (prechg_o),
  .scan_dir_o (scan_dir_o),
  .done_o     (done_o)
);

// File: tb/vscan_gen_tb_top.sv
module vscan_gen_tb_top;

  localparam int LINE = 512;
  localparam int NL   = 5;

  // {tick, gate_en, prechg, vst} for the first row line
  localparam int VEC[12][4] = '{
    '{0, 0, 0, 1}, '{17, 0, 0, 1}, '{18, 1, 0, 1}, '{65, 1, 0, 1},
    '{66, 0, 0, 1}, '{255, 0, 0, 1}, '{256, 0, 0, 0}, '{483, 0, 0, 0},
    '{484, 0, 1, 0}, '{503, 0, 1, 0}, '{504, 0, 0, 0}, '{511, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line_stb = 1'b0, frame_stb = 1'b0, scan_down = 1'b0;
  logic vst, vclk_a, vclk_b, gate_en, prechg, scan_dir, done;

  int total = 0, bad = 0, pos = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  vscan_gen #(.NUM_LINES(NL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .line_stb_i(line_stb), .frame_stb_i(frame_stb),
    .scan_down_i(scan_down), .vst_o(vst), .vclk_a_o(vclk_a), .vclk_b_o(vclk_b),
    .gate_en_o(gate_en), .prechg_o(prechg), .scan_dir_o(scan_dir), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at tick %0d: actual=%0d expected=%0d", req, pos, act, exp);
    end
  endtask

  task automatic pulse(input logic ln, input logic fr);
    line_stb  = ln;
    frame_stb = fr;
    @(negedge clk);
    line_stb  = 1'b0;
    frame_stb = 1'b0;
    pos = 0;
  endtask

  task automatic goto(input int t);
    repeat (t - pos) @(negedge clk);
    pos = t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 vst", vst, 0);
    check("R9 gate_en", gate_en, 0);
    check("R9 prechg", prechg, 0);
    check("R9 vclk_a", vclk_a, 0);
    check("R9 vclk_b", vclk_b, 1);
    check("R9 done", done, 0);
    check("R9 scan_dir", scan_dir, 0);

    // R10: strobe with no frame armed
    pulse(1'b1, 1'b0);
    check("R10 vclk_a", vclk_a, 0);
    goto(20);
    check("R10 gate_en", gate_en, 0);
    goto(300);
    check("R10 vst", vst, 0);
    goto(LINE - 1);

    // R8: frame and line strobe together
    scan_down = 1'b1;
    pulse(1'b1, 1'b1);
    check("R8 vclk_a", vclk_a, 0);
    check("R1 scan_dir", scan_dir, 1);
    goto(300);
    check("R8 vst", vst, 0);
    goto(LINE - 1);

    // lead-in line
    pulse(1'b1, 1'b0);
    scan_down = 1'b0;
    check("R2 vclk_a", vclk_a, 0);
    goto(20);
    check("R2 gate_en", gate_en, 0);
    goto(255);
    check("R2 vst", vst, 0);
    goto(256);
    check("R2 vst", vst, 1);
    goto(490);
    check("R2 prechg", prechg, 0);
    goto(LINE - 1);

    // first row line: vector walk
    pulse(1'b1, 1'b0);
    check("R4 vclk_a", vclk_a, 1);
    check("R4 vclk_b", vclk_b, 0);
    for (int i = 0; i < 12; i++) begin
      goto(VEC[i][0]);
      check("R5 gate_en", gate_en, VEC[i][1]);
      check("R6 prechg", prechg, VEC[i][2]);
      check("R3 vst", vst, VEC[i][3]);
    end
    check("R1 scan_dir", scan_dir, 1);
    goto(LINE - 1);

    for (int ln = 2; ln <= NL; ln++) begin
      pulse(1'b1, 1'b0);
      check("R4 vclk_a", vclk_a, ln % 2);
      check("R7 done", done, 0);
      goto(40);
      check("R5 gate_en", gate_en, 1);
      goto(495);
      check("R6 prechg", prechg, 1);
      goto(LINE - 1);
    end

    // closing strobe
    pulse(1'b1, 1'b0);
    check("R7 done", done, 1);
    check("R7 vclk_a", vclk_a, 1);
    goto(20);
    check("R7 gate_en", gate_en, 0);
    goto(490);
    check("R7 prechg", prechg, 0);
    goto(LINE - 1);
    pulse(1'b1, 1'b0);
    check("R7 vclk_a", vclk_a, 1);
    check("R7 done", done, 1);
    goto(10);

    // new frame clears done and takes the new direction
    pulse(1'b0, 1'b1);
    check("R7 done", done, 0);
    check("R1 scan_dir", scan_dir, 0);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule